// File: doc/BRIEF.md
# I2C Slave Address Comparator (7-bit and 10-bit)

This block sits behind the byte receiver of an I2C target. It decides whether the first byte after a START or a repeated START addresses this device. The byte is checked against a programmed 7-bit own address. When it matches, the block raises an addressed-as-target flag. It also records the direction bit of that first byte.

In 7-bit mode only the seven address bits count, and the direction bit of the byte is not compared. In 10-bit mode the whole first byte must match, and its trailing direction bit is compared against a direction-compare bit. Software holds that compare bit and can write it at any time.

The block does not check the second address byte of a 10-bit transfer; software does that. Once software has confirmed the second byte, it sets the compare bit to 1. The first byte sent after the following repeated START then matches address and read direction together in one comparison. ACK generation and the data phase belong to other blocks.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `addressed`, `rx_dir` and `dir_cmp` are 0, and no byte is evaluated until a START has been seen.
- R2: With `ten_bit_mode` = 0, the first byte after a START sets `addressed` exactly when `rx_byte[7:1]` equals `own_addr`, whatever the values of `rx_byte[0]` and `dir_cmp`.
- R3: With `ten_bit_mode` = 1, the first byte after a START sets `addressed` only when `rx_byte[7:1]` equals `own_addr` and `rx_byte[0]` equals `dir_cmp`.
- R4: A first byte after a START or repeated START that does not match clears `addressed`, even if it was set before.
- R5: Only the first byte after a START or repeated START is evaluated. Later bytes, and bytes that arrive with no START before them, leave `addressed` and `rx_dir` unchanged.
- R6: `stop_det` clears `addressed` on the next cycle and disarms evaluation. It takes priority over a `start_det` or `rx_valid` in the same cycle.
- R7: The evaluated first byte loads `rx_byte[0]` into `rx_dir` (1 = read), whether or not it matched. A STOP leaves `rx_dir` unchanged.
- R8: A pulse on `dir_cmp_we` loads `dir_cmp_wdata` into `dir_cmp`, and the new value is visible one cycle later. The write is accepted in any cycle.
- R9: An `rx_valid` in the same cycle as `start_det` (with no STOP) is not evaluated. The byte that follows it is the one evaluated.
- R10: `addressed` keeps its value across a repeated START until the first byte after that repeated START has been evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_det | input | 1 | One-cycle pulse: START or repeated START seen |
| stop_det | input | 1 | One-cycle pulse: STOP seen |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a complete byte |
| rx_byte | input | ADDR_W+1 | Received byte; bits [7:1] are the address, bit [0] is the direction |
| ten_bit_mode | input | 1 | 0 = 7-bit addressing, 1 = 10-bit addressing |
| own_addr | input | ADDR_W | Programmed own address |
| dir_cmp_we | input | 1 | Write enable for the direction-compare bit |
| dir_cmp_wdata | input | 1 | Value to write into the direction-compare bit |
| dir_cmp | output | 1 | Current direction-compare bit |
| addressed | output | 1 | Addressed-as-target flag |
| rx_dir | output | 1 | Direction bit captured from the first byte |

## Verification
The main sweep runs every one of the 256 first-byte values against four own addresses (all zeros, all ones and two alternating patterns). Each byte is tried in both modes and with both compare-bit values. This separates a comparison that ignores the direction bit from one that checks it, and it catches any single-bit address mismatch. After each evaluated byte, a second byte that differs from it in every address bit shows whether later bytes are wrongly re-evaluated. Directed sequences then cover the orderings: a repeated START with no byte after it, a START and a byte in the same cycle, a STOP together with a START, bytes sent with no START, and the software write that turns a 10-bit first byte into a read match.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

  typedef enum logic {
    AM_MODE_7BIT  = 1'b0,
    AM_MODE_10BIT = 1'b1
  } am_mode_e;

  // Match decision: in 10-bit mode the direction bit also has to agree.
  function automatic logic am_hit(input logic addr_eq, input logic dir_eq,
                                  input am_mode_e mode);
    return addr_eq && ((mode == AM_MODE_7BIT) || dir_eq);
  endfunction

endpackage

// File: rtl/i2c_am_cmpbit.sv
module i2c_am_cmpbit (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic wdata,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= 1'b0;
    else if (we) q <= wdata;
  end

  // R8
  cmp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(wdata)));
  // R8
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/i2c_am_window.sv
module i2c_am_window (
  input  logic clk,
  input  logic rst_n,
  input  logic start_det,
  input  logic stop_det,
  input  logic rx_valid,
  output logic armed,
  output logic eval_now
);
  always_ff @(posedge clk) begin
    if (!rst_n)         armed <= 1'b0;
    else if (stop_det)  armed <= 1'b0;
    else if (start_det) armed <= 1'b1;
    else if (rx_valid)  armed <= 1'b0;
  end

  assign eval_now = armed && rx_valid && !start_det && !stop_det;

  // R6
  stop_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !armed);
  // R9
  start_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> armed);
  // R5
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_now |=> !armed);
endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp
  import i2c_am_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W:0]   rx_byte,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              dir_cmp,
  input  am_mode_e          mode,
  output logic              hit,
  output logic              rw_bit
);
  logic [ADDR_W-1:0] bit_eq;

  genvar i;
  generate
    for (i = 0; i < ADDR_W; i++) begin : g_eq
      assign bit_eq[i] = ~(rx_byte[i+1] ^ own_addr[i]);
    end
  endgenerate

  assign rw_bit = rx_byte[0];
  assign hit    = am_hit(&bit_eq, rw_bit == dir_cmp, mode);

  // R2
  always_comb begin
    if (mode == AM_MODE_7BIT)
      mode7_chk: assert (hit == (rx_byte[ADDR_W:1] == own_addr));
  end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              rx_valid,
  input  logic [ADDR_W:0]   rx_byte,
  input  logic              ten_bit_mode,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              dir_cmp_we,
  input  logic              dir_cmp_wdata,
  output logic              dir_cmp,
  output logic              addressed,
  output logic              rx_dir
);
  logic     armed;
  logic     eval_now;
  logic     hit;
  logic     rw_bit;
  am_mode_e mode;

  assign mode = am_mode_e'(ten_bit_mode);

  i2c_am_cmpbit u_cmpbit (
    .clk(clk), .rst_n(rst_n), .we(dir_cmp_we), .wdata(dir_cmp_wdata), .q(dir_cmp)
  );

  i2c_am_window u_window (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
    .rx_valid(rx_valid), .armed(armed), .eval_now(eval_now)
  );

  i2c_am_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .rx_byte(rx_byte), .own_addr(own_addr), .dir_cmp(dir_cmp), .mode(mode),
    .hit(hit), .rw_bit(rw_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addressed <= 1'b0;
      rx_dir    <= 1'b0;
    end else if (stop_det) begin
      addressed <= 1'b0;
    end else if (eval_now) begin
      addressed <= hit;
      rx_dir    <= rw_bit;
    end
  end

  // R6
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !addressed);
  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eval_now && !stop_det) |=> $stable(addressed));
  // R7
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_now |=> $stable(rx_dir));
  // R3
  eval_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_now |=> (addressed == $past(hit)));
  // R7
  dir_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_now |=> (rx_dir == $past(rx_byte[0])));
  // R10
  restart_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> $stable(addressed));
endmodule

// File: tb/i2c_addr_match_bench.sv
module i2c_addr_match_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_det = 1'b0, stop_det = 1'b0, rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       ten_bit_mode = 1'b0;
  logic [6:0] own_addr = 7'h00;
  logic       dir_cmp_we = 1'b0, dir_cmp_wdata = 1'b0;
  logic       dir_cmp, addressed, rx_dir;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_addr_match u_i2c_addr_match (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .ten_bit_mode(ten_bit_mode),
    .own_addr(own_addr), .dir_cmp_we(dir_cmp_we), .dir_cmp_wdata(dir_cmp_wdata),
    .dir_cmp(dir_cmp), .addressed(addressed), .rx_dir(rx_dir)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // One cycle of stimulus; at return the registered result is visible.
  task automatic pulse(input logic s, input logic p, input logic v, input logic [7:0] b);
    @(negedge clk);
    start_det = s; stop_det = p; rx_valid = v; rx_byte = b;
    @(negedge clk);
    start_det = 1'b0; stop_det = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic write_cmp(input logic v);
    @(negedge clk);
    dir_cmp_we = 1'b1; dir_cmp_wdata = v;
    @(negedge clk);
    dir_cmp_we = 1'b0;
  endtask

  function automatic logic expect_hit(input logic [7:0] b, input logic [6:0] a,
                                      input logic ten, input logic c);
    logic addr_ok;
    addr_ok = (b >> 1) == {1'b0, a};
    if (ten) return addr_ok && (b[0] == c);
    return addr_ok;
  endfunction

  initial begin
    logic [6:0] addrs [4];
    logic       e;
    addrs[0] = 7'h00; addrs[1] = 7'h7F; addrs[2] = 7'h55; addrs[3] = 7'h2A;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 addressed", addressed, 1'b0);
    check("R1 rx_dir", rx_dir, 1'b0);
    check("R1 dir_cmp", dir_cmp, 1'b0);
    rst_n = 1'b1;
    own_addr = 7'h3C;
    // R1: no evaluation before any START
    pulse(1'b0, 1'b0, 1'b1, 8'h79);
    check("R1 no start", addressed, 1'b0);
    check("R1 no start dir", rx_dir, 1'b0);

    // Sweep: R2 / R3 / R7 / R5
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 2; c++) begin
        write_cmp(c[0]);
        check("R8 write", dir_cmp, c[0]);
        ten_bit_mode = m[0];
        for (int k = 0; k < 4; k++) begin
          own_addr = addrs[k];
          for (int bv = 0; bv < 256; bv++) begin
            e = expect_hit(bv[7:0], addrs[k], m[0], c[0]);
            pulse(1'b0, 1'b1, 1'b0, 8'h00);
            pulse(1'b1, 1'b0, 1'b0, 8'h00);
            pulse(1'b0, 1'b0, 1'b1, bv[7:0]);
            check(m[0] ? "R3 match" : "R2 match", addressed, e);
            check("R7 dir", rx_dir, bv[0]);
            pulse(1'b0, 1'b0, 1'b1, bv[7:0] ^ 8'hFF);
            check("R5 later byte", addressed, e);
            check("R5 later dir", rx_dir, bv[0]);
          end
        end
      end
    end

    // R4 / R10: flag across repeated START, then a failing first byte
    ten_bit_mode = 1'b0; own_addr = 7'h12;
    pulse(1'b1, 1'b0, 1'b0, 8'h00);
    pulse(1'b0, 1'b0, 1'b1, 8'h24);
    check("R2 set", addressed, 1'b1);
    pulse(1'b1, 1'b0, 1'b0, 8'h00);
    check("R10 restart hold", addressed, 1'b1);
    pulse(1'b0, 1'b0, 1'b1, 8'h25);
    check("R10 restart rematch", addressed, 1'b1);
    pulse(1'b1, 1'b0, 1'b0, 8'h00);
    pulse(1'b0, 1'b0, 1'b1, 8'h40);
    check("R4 mismatch clears", addressed, 1'b0);

    // R9: byte together with START is not evaluated
    pulse(1'b1, 1'b0, 1'b1, 8'h24);
    check("R9 same-cycle byte", addressed, 1'b0);
    pulse(1'b0, 1'b0, 1'b1, 8'h24);
    check("R9 next byte", addressed, 1'b1);

    // R6: STOP wins over START and byte; disarmed afterwards; rx_dir kept
    pulse(1'b1, 1'b0, 1'b0, 8'h00);
    pulse(1'b0, 1'b0, 1'b1, 8'h25);
    check("R7 read dir", rx_dir, 1'b1);
    pulse(1'b1, 1'b1, 1'b1, 8'h25);
    check("R6 stop clears", addressed, 1'b0);
    check("R7 dir kept on stop", rx_dir, 1'b1);
    pulse(1'b0, 1'b0, 1'b1, 8'h24);
    check("R6 disarmed", addressed, 1'b0);

    // R3 / R8: 10-bit flow, software arms read match
    ten_bit_mode = 1'b1; own_addr = 7'h78;
    write_cmp(1'b0);
    pulse(1'b1, 1'b0, 1'b0, 8'h00);
    pulse(1'b0, 1'b0, 1'b1, 8'hF0);
    check("R3 write first byte", addressed, 1'b1);
    pulse(1'b0, 1'b0, 1'b1, 8'h5A);
    check("R5 second byte stored only", addressed, 1'b1);
    write_cmp(1'b1);
    check("R8 set by software", dir_cmp, 1'b1);
    pulse(1'b1, 1'b0, 1'b0, 8'h00);
    pulse(1'b0, 1'b0, 1'b1, 8'hF1);
    check("R3 read after restart", addressed, 1'b1);
    check("R7 read dir", rx_dir, 1'b1);
    pulse(1'b1, 1'b0, 1'b0, 8'h00);
    pulse(1'b0, 1'b0, 1'b1, 8'hF0);
    check("R3 write now rejected", addressed, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule